// File: doc/BRIEF.md
# Reset-Counting Integrator Controller

This block is the digital half of a current-to-frequency front end. An analog integrator ramps at a rate set by the input current. A comparator flags each time the ramp crosses a threshold. The block brings that comparator signal into the clock domain and answers every crossing with a reset pulse of programmable length, which discharges the feedback capacitor. It also counts those pulses over a programmable measurement window.

When a window ends, the block latches two results: the pulse count and the total number of clock cycles the integrator spent in reset. Downstream arithmetic can then divide by the effective integration time, which is the window length minus the dead time, instead of the raw window. The next window starts on the following cycle with no gap. At 50 MHz a 100 ms window is 5,000,000 cycles, and the default window counter is wide enough for that.

Pulse generation runs as a two-state machine. ST_IDLE waits for an accepted comparator edge. The START transition moves it to ST_PULSE and loads the length counter. HOLD keeps it in ST_PULSE while cycles remain. DONE returns it to ST_IDLE after the last reset cycle.

Top module: `icfc_reset_ctrl`

## Requirements
- R1: A rising edge on `cmp_i` passes a two-flop synchronizer and an edge detector. If the comparator goes high before clock edge k, `int_rst_o` is high from clock edge k+2 onward, a fixed latency of three rising edges.
- R2: Each reset pulse keeps `int_rst_o` high for exactly `pulse_len_i` clock cycles. A value of 0 is treated as 1.
- R3: A comparator rising edge that arrives while a reset pulse is active is ignored. It starts no further pulse and is not counted.
- R4: A measurement window lasts `win_len_i` cycles, with a minimum of 1. The first window begins on the first clock after reset release. `valid_o` is high for one cycle after each window, that is after rising edges W, 2W, 3W and so on.
- R5: `count_o` reports the number of reset pulses started within the window that just ended.
- R6: `dead_o` reports the sum of the lengths of those pulses, which is the count times the effective pulse length, in clock cycles.
- R7: The internal totals restart from zero for the next window with no idle cycle. A window with no crossings reports a count of 0, a dead time of 0 and no overflow.
- R8: When more pulses occur than `count_o` can hold, the count and dead time stop at their values at saturation (count all ones), and `ovf_o` is reported high with that window's result. The flag clears for the next window.
- R9: While reset is asserted, `int_rst_o`, `valid_o`, `ovf_o`, `count_o` and `dead_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Asynchronous comparator output, high at threshold crossing |
| win_len_i | input | WIN_W | Measurement window length in clock cycles |
| pulse_len_i | input | PL_W | Reset pulse length in clock cycles (0 acts as 1) |
| int_rst_o | output | 1 | Drive for the integrator feedback-capacitor reset switch |
| count_o | output | CNT_W | Pulses in the last completed window |
| dead_o | output | CNT_W+PL_W | Reset cycles in the last completed window |
| ovf_o | output | 1 | Count saturated during the last completed window |
| valid_o | output | 1 | One-cycle strobe marking new results |

## Verification
The bench uses four stimulus patterns:
- **Clean crossings with a mid-length pulse.** This separates correct counting and dead-time scaling from an off-by-one in pulse length or latency.
- **Long pulses with a second comparator edge forced inside each pulse.** This separates a controller that ignores edges during reset from one that re-triggers or counts them.
- **A zero pulse length.** This checks the one-cycle floor.
- **A burst of more crossings than the counter can hold.** This distinguishes saturation with a flag from wrap-around.

Every pattern is followed by an empty window, which shows whether the totals clear. The times at which the strobe appears show whether the window boundary sits where it should.

// File: rtl/icfc_pkg.sv
package icfc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pulse_st_e;
endpackage

// File: rtl/icfc_edge_sync.sv
module icfc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmp_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= cmp_i;
            end
        end else begin : g_many
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q <= '0;
                else         chain_q <= {chain_q[STAGES-2:0], cmp_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= chain_q[STAGES-1];
    end

    assign edge_o = chain_q[STAGES-1] & ~prev_q;

    // R1
    edge_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |=> !edge_o);
endmodule

// File: rtl/icfc_pulse_fsm.sv
module icfc_pulse_fsm
    import icfc_pkg::*;
#(
    parameter int PL_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            edge_i,
    input  logic [PL_W-1:0] len_i,
    output logic            start_o,
    output logic            int_rst_o
);
    pulse_st_e       state_q, state_d;
    logic [PL_W-1:0] left_q, left_d;

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (edge_i) begin
                    state_d = ST_PULSE;
                    left_d  = len_i - 1'b1;
                end
            end
            ST_PULSE: begin
                if (left_q == '0) state_d = ST_IDLE;
                else              left_d  = left_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        start_o   = 1'b0;
        int_rst_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_o   = edge_i;
            ST_PULSE: int_rst_o = 1'b1;
            default: ;
        endcase
    end

    // R1
    latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_rst_o) |-> $past(edge_i));
endmodule

// File: rtl/icfc_window_timer.sv
module icfc_window_timer #(
    parameter int WIN_W = 23
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIN_W-1:0] win_len_i,
    output logic             tick_o
);
    logic [WIN_W-1:0] tmr_q;
    logic [WIN_W:0]   next_ext;

    assign next_ext = {1'b0, tmr_q} + 1'b1;
    assign tick_o   = next_ext >= {1'b0, win_len_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     tmr_q <= '0;
        else if (tick_o) tmr_q <= '0;
        else             tmr_q <= tmr_q + 1'b1;
    end
endmodule

// File: rtl/icfc_accum.sv
module icfc_accum #(
    parameter int CNT_W  = 16,
    parameter int PL_W   = 8,
    localparam int DEAD_W = CNT_W + PL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [PL_W-1:0]   len_i,
    input  logic              tick_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [DEAD_W-1:0] dead_o,
    output logic              ovf_o,
    output logic              valid_o
);
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [DEAD_W-1:0] dead_q, dead_d;
    logic              ovf_q, ovf_d, full;

    assign full = (cnt_q == '1);

    always_comb begin
        cnt_d  = cnt_q;
        dead_d = dead_q;
        ovf_d  = ovf_q;
        if (start_i) begin
            if (full) begin
                ovf_d = 1'b1;
            end else begin
                cnt_d  = cnt_q + 1'b1;
                dead_d = dead_q + DEAD_W'(len_i);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            dead_q  <= '0;
            ovf_q   <= 1'b0;
            count_o <= '0;
            dead_o  <= '0;
            ovf_o   <= 1'b0;
            valid_o <= 1'b0;
        end else if (tick_i) begin
            count_o <= cnt_d;
            dead_o  <= dead_d;
            ovf_o   <= ovf_d;
            valid_o <= 1'b1;
            cnt_q   <= '0;
            dead_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            dead_q  <= dead_d;
            ovf_q   <= ovf_d;
            valid_o <= 1'b0;
        end
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full && !tick_i) |=> (cnt_q == '1));
    // R8
    ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && ovf_o) |-> (count_o == '1));
endmodule

// File: rtl/icfc_reset_ctrl.sv
module icfc_reset_ctrl #(
    parameter int WIN_W  = 23,
    parameter int PL_W   = 8,
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2,
    localparam int DEAD_W = CNT_W + PL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmp_i,
    input  logic [WIN_W-1:0]  win_len_i,
    input  logic [PL_W-1:0]   pulse_len_i,
    output logic              int_rst_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [DEAD_W-1:0] dead_o,
    output logic              ovf_o,
    output logic              valid_o
);
    logic            cmp_edge, pulse_start, win_tick;
    logic [PL_W-1:0] len_eff;

    assign len_eff = (pulse_len_i == '0) ? PL_W'(1) : pulse_len_i;

    icfc_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .cmp_i(cmp_i), .edge_o(cmp_edge)
    );

    icfc_pulse_fsm #(.PL_W(PL_W)) u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(cmp_edge), .len_i(len_eff),
        .start_o(pulse_start), .int_rst_o(int_rst_o)
    );

    icfc_window_timer #(.WIN_W(WIN_W)) u_win (
        .clk_i(clk_i), .rst_ni(rst_ni), .win_len_i(win_len_i), .tick_o(win_tick)
    );

    icfc_accum #(.CNT_W(CNT_W), .PL_W(PL_W)) u_acc (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(pulse_start), .len_i(len_eff),
        .tick_i(win_tick), .count_o(count_o), .dead_o(dead_o), .ovf_o(ovf_o),
        .valid_o(valid_o)
    );

    // R3
    no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_rst_o && cmp_edge) |-> !pulse_start);
endmodule

// File: tb/test_icfc_reset_ctrl.sv
module test_icfc_reset_ctrl;
    localparam int WIN_W = 23;
    localparam int PL_W  = 8;
    localparam int CNT_W = 4;
    localparam int DW    = CNT_W + PL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    dead;
        logic             ovf;
    } res_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp = 1'b0;
    logic [WIN_W-1:0] win_len = 23'd100;
    logic [PL_W-1:0]  plen = 8'd4;
    logic             int_rst, ovf, valid;
    logic [CNT_W-1:0] count;
    logic [DW-1:0]    dead;

    int   checks = 0;
    int   errors = 0;
    int   pe = 0;
    int   cyc = 0;
    bit   prev_valid = 1'b0;
    res_t exp_q[$];

    always #10 clk = ~clk;

    icfc_reset_ctrl #(.WIN_W(WIN_W), .PL_W(PL_W), .CNT_W(CNT_W)) i_icfc_reset_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .win_len_i(win_len),
        .pulse_len_i(plen), .int_rst_o(int_rst), .count_o(count), .dead_o(dead),
        .ovf_o(ovf), .valid_o(valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst_n) pe++;
        else       pe = 0;
    end

    // monitor: pop expected results as the design reports them
    always @(negedge clk) begin
        if (rst_n && valid) begin
            res_t e;
            chk(!prev_valid || win_len < 2, "R4", "valid width", 2, 1);
            chk((pe % int'(win_len)) == 0, "R4", "window boundary", pe, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected result", count, -1);
            end else begin
                e = exp_q.pop_front();
                chk(count == e.cnt, "R5", "count", count, e.cnt);
                chk(dead == e.dead, "R6", "dead time", dead, e.dead);
                chk(ovf == e.ovf, "R8", "overflow", ovf, e.ovf);
            end
        end
        prev_valid = rst_n && valid;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            chk(1'b0, "WDOG", "watchdog cycles", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_reset(input int w, input int p);
        @(negedge clk);
        rst_n   = 1'b0;
        cmp     = 1'b0;
        win_len = WIN_W'(w);
        plen    = PL_W'(p);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input int p, input bit retrig);
        int hi;
        int pe_eff;
        pe_eff = (p == 0) ? 1 : p;
        @(negedge clk);
        cmp = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(int_rst == 1'b1, "R1", "reset latency", int_rst, 1);
        hi = 0;
        while (int_rst === 1'b1 && hi < 300) begin
            hi++;
            if (hi == 1) cmp = 1'b0;
            if (retrig && hi == 2) cmp = 1'b1;
            if (retrig && hi == 3) cmp = 1'b0;
            @(negedge clk);
        end
        chk(hi == pe_eff, "R2", "pulse width", hi, pe_eff);
        for (int k = 0; k < 6; k++) begin
            if (int_rst !== 1'b0) begin
                chk(1'b0, "R3", "extra pulse", int_rst, 0);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_res(input int c, input int d, input bit o);
        res_t r;
        r.cnt  = CNT_W'(c);
        r.dead = DW'(d);
        r.ovf  = o;
        exp_q.push_back(r);
    endtask

    task automatic drain(input int w);
        int t = 0;
        while (exp_q.size() != 0 && t < 3 * w + 20) begin
            @(negedge clk);
            t++;
        end
        chk(exp_q.size() == 0, "R7", "results pending", exp_q.size(), 0);
    endtask

    initial begin
        // R9: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(int_rst == 1'b0, "R9", "int_rst in reset", int_rst, 0);
        chk(valid == 1'b0, "R9", "valid in reset", valid, 0);
        chk(count == '0, "R9", "count in reset", count, 0);
        chk(dead == '0, "R9", "dead in reset", dead, 0);
        chk(ovf == 1'b0, "R9", "ovf in reset", ovf, 0);

        // R5 R6 R7: three clean crossings, pulse length 4, then empty window
        do_reset(200, 4);
        expect_res(3, 12, 1'b0);
        expect_res(0, 0, 1'b0);
        for (int i = 0; i < 3; i++) fire(4, 1'b0);
        drain(200);

        // R3: long pulses with an edge inside each
        do_reset(150, 10);
        expect_res(2, 20, 1'b0);
        expect_res(0, 0, 1'b0);
        for (int i = 0; i < 2; i++) fire(10, 1'b1);
        drain(150);

        // R2: zero length acts as one cycle
        do_reset(100, 0);
        expect_res(2, 2, 1'b0);
        expect_res(0, 0, 1'b0);
        for (int i = 0; i < 2; i++) fire(0, 1'b0);
        drain(100);

        // R8: 18 crossings into a 4-bit counter saturate at 15, then clear
        do_reset(400, 2);
        expect_res(15, 30, 1'b1);
        expect_res(0, 0, 1'b0);
        for (int i = 0; i < 18; i++) fire(2, 1'b0);
        drain(400);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule